// File: doc/BRIEF.md
# Write-Only Serial Bus Slave with Deferred Word Commit

This block is a receive-only target on a two-wire serial bus (I2C signalling). The clock and data lines are sampled by the system clock, which must run at least eight times faster than the bus clock. The block recognises START, repeated START and STOP conditions. It answers a single fixed 7-bit address, and only when the direction bit asks for a write. It acknowledges each byte it accepts by pulling the data line low through an open-drain enable.

After its address, the block takes exactly three data bytes into holding latches. Nothing reaches the 24-bit output word when the bytes arrive. A completed set of three bytes waits as a pending word. That word survives any number of repeated STARTs aimed at other targets and is applied on the next STOP seen on the bus. When the output word is loaded, a one-cycle strobe marks the update. Transfers that are cut short never disturb the last complete word. A STOP that comes while this block is part-way through its data bytes is refused.

Top module: `i2c_deferred_wr_slave`

## Requirements
- R1: After synchronous reset, `data_out` is 0, `update_strobe` is 0, `sda_oe` is 0, and no word is pending.
- R2: A first byte of 8'h36 after START is acknowledged. That byte is address 7'b0011011 followed by direction bit 0, sent MSB first. The acknowledge holds SDA low for the whole high phase of the ninth bus clock.
- R3: Any other first byte is not acknowledged, and `sda_oe` is never asserted for it. This includes 8'h37, which is the matching address with direction bit 1. Bus traffic up to the next START then has no effect.
- R4: After an acknowledged address, three data bytes are each acknowledged. The first of them becomes `data_out[23:16]` and the last becomes `data_out[7:0]`.
- R5: A STOP after a complete three-byte set loads `data_out`. `update_strobe` is high for exactly the one cycle in which the new value first appears, and `data_out` changes in no other cycle.
- R6: A complete pending word stays pending through repeated STARTs addressed to other targets. It is applied on the next STOP.
- R7: A STOP after the address is acknowledged but before the third data byte is acknowledged leaves `data_out` unchanged and discards any pending word. A later STOP without a new complete set changes nothing.
- R8: If a word is pending and a repeated START re-addresses this block, the new three bytes replace the pending word. The following STOP applies the new word.
- R9: Bytes after the third in one addressed transfer are not acknowledged and do not change the word that is applied.
- R10: `sda_oe` is asserted only while SCL is low. It is released on the SCL falling edge that ends the acknowledge clock, and it is clear after any STOP.
- R11: A repeated START in the middle of a new data set leaves the previously completed pending word intact. A later STOP applies that earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 = pull the data line low (open-drain enable) |
| data_out | output | 24 | Last applied 24-bit word |
| update_strobe | output | 1 | One-cycle pulse in the cycle `data_out` is loaded |

## Verification
A wrong pending flag or transfer state does not show until the next STOP. At that point `data_out` either moves when it should hold, or holds when it should move, three system clocks after the data line rises. A bad bit counter or address decode shows sooner, as a missing or extra acknowledge in the ninth bus clock of the byte concerned. The bench checks both: it compares the word and strobe with a behavioural model on every cycle, and it samples the acknowledge at each ninth clock.

// File: rtl/i2c_dw_pkg.sv
package i2c_dw_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,   // not addressed; waits for START
    RX_ADDR = 2'd1,   // shifting the address byte
    RX_DATA = 2'd2,   // addressed, data set incomplete
    RX_FULL = 2'd3    // data set complete; further bytes refused
  } rx_state_t;

  localparam int BIT_CNT_W = 4;
endpackage

// File: rtl/i2c_dw_sync.sv
module i2c_dw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '1;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_dw_cond.sv
module i2c_dw_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_det = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q &  sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_dw_rx.sv
module i2c_dw_rx
  import i2c_dw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0011011,
  parameter int         NBYTES   = 3,
  parameter int         BYTE_W   = 8,
  localparam int        WORD_W   = NBYTES * BYTE_W,
  localparam int        IDX_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  output logic              sda_oe,
  output logic              commit,
  output logic [WORD_W-1:0] pend_word
);
  localparam logic [BIT_CNT_W-1:0] CNT_BYTE = BIT_CNT_W'(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] CNT_ACK  = BIT_CNT_W'(BYTE_W + 1);
  localparam logic [IDX_W-1:0]     IDX_LAST = IDX_W'(NBYTES - 1);

  rx_state_t              state;
  logic [BIT_CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]      shreg;
  logic [IDX_W-1:0]       idx;
  logic [BYTE_W-1:0]      hold [NBYTES];
  logic                   pend;
  logic [WORD_W-1:0]      full_word;

  // Word formed from earlier latched bytes plus the byte now in the shifter.
  always_comb begin
    full_word = '0;
    for (int k = 0; k < NBYTES - 1; k++)
      full_word[(NBYTES-1-k)*BYTE_W +: BYTE_W] = hold[k];
    full_word[BYTE_W-1:0] = shreg;
  end

  // A STOP is refused while a data set is only partly received.
  assign commit = stop_det & pend & (state != RX_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      idx       <= '0;
      sda_oe    <= 1'b0;
      pend      <= 1'b0;
      pend_word <= '0;
    end else if (start_det) begin
      state   <= RX_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= RX_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (scl_rise && state != RX_IDLE && bit_cnt < CNT_BYTE) begin
        shreg   <= {shreg[BYTE_W-2:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end else if (scl_rise && bit_cnt == CNT_BYTE) begin
        bit_cnt <= CNT_ACK;
      end

      if (scl_fall && bit_cnt == CNT_BYTE) begin
        unique case (state)
          RX_ADDR: begin
            if (shreg == {DEV_ADDR, 1'b0}) sda_oe <= 1'b1;
            else                           state  <= RX_IDLE;
          end
          RX_DATA: begin
            sda_oe    <= 1'b1;
            hold[idx] <= shreg;
            if (idx == IDX_LAST) begin
              pend      <= 1'b1;
              pend_word <= full_word;
            end
          end
          default: ;
        endcase
      end

      if (scl_fall && bit_cnt == CNT_ACK) begin
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        if (state == RX_ADDR) begin
          state <= RX_DATA;
          idx   <= '0;
        end else if (state == RX_DATA) begin
          if (idx == IDX_LAST) state <= RX_FULL;
          else                 idx   <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_deferred_wr_slave.sv
module i2c_deferred_wr_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b0011011,
  parameter int         NBYTES      = 3,
  parameter int         BYTE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        WORD_W      = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [WORD_W-1:0] data_out,
  output logic              update_strobe
);
  logic              scl_s, sda_s;
  logic              start_det, stop_det, scl_rise, scl_fall;
  logic              commit;
  logic [WORD_W-1:0] pend_word;

  i2c_dw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   ({scl_s, sda_s})
  );

  i2c_dw_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  i2c_dw_rx #(.DEV_ADDR(DEV_ADDR), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_oe    (sda_oe),
    .commit    (commit),
    .pend_word (pend_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out      <= '0;
      update_strobe <= 1'b0;
    end else begin
      update_strobe <= commit;
      if (commit) data_out <= pend_word;
    end
  end
endmodule

// File: rtl/i2c_dw_checker.sv
module i2c_dw_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              update_strobe,
  input logic [WORD_W-1:0] data_out
);
  // R10: the acknowledge pull-down only starts while SCL is low.
  p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R10: the pull-down is released on an SCL fall (or on STOP/START).
  p_oe_fall_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_s || $past(stop_det) || $past(scl_s));

  // R10: after a STOP the data line is not driven.
  p_oe_clear_after_stop_r10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R5: the strobe is a single-cycle pulse.
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    update_strobe |=> !update_strobe);

  // R5: the strobe only follows a STOP on the bus.
  p_strobe_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
    update_strobe |-> $past(stop_det));

  // R5: the output word moves only together with the strobe.
  p_word_moves_with_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_out) |-> update_strobe);
endmodule

bind i2c_deferred_wr_slave i2c_dw_checker #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_s         (scl_s),
  .stop_det      (stop_det),
  .sda_oe        (sda_oe),
  .update_strobe (update_strobe),
  .data_out      (data_out)
);

// File: tb/i2c_deferred_wr_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_deferred_wr_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [23:0] data_out;
  logic        update_strobe;
  logic        sda_bus;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;   // 100 MHz

  assign sda_bus = sda_m & ~sda_oe;

  i2c_deferred_wr_slave dut_i (
    .clk           (clk),
    .rst           (rst),
    .scl_in        (scl_m),
    .sda_in        (sda_bus),
    .sda_oe        (sda_oe),
    .data_out      (data_out),
    .update_strobe (update_strobe)
  );

  // ---------------- behavioural reference model ----------------
  logic [1:0] s1 = 2'b11, s2 = 2'b11, s3 = 2'b11;
  int          m_state;          // 0 idle, 1 address, 2 data, 3 full
  int          m_cnt;
  int          m_idx;
  logic [7:0]  m_sh;
  logic [7:0]  m_bytes [$];
  bit          m_pend;
  logic [23:0] m_word;
  logic [23:0] exp_data;
  bit          exp_stb;

  always @(posedge clk) begin
    if (rst) begin
      s1 <= 2'b11; s2 <= 2'b11; s3 <= 2'b11;
      m_state = 0; m_cnt = 0; m_idx = 0; m_sh = '0;
      m_pend = 0; m_word = '0; exp_data = '0; exp_stb = 0;
      m_bytes.delete();
    end else begin
      logic sc, sd, pc, pd;
      sc = s2[1]; sd = s2[0]; pc = s3[1]; pd = s3[0];
      exp_stb = 0;
      if (sc && pc && pd && !sd) begin
        m_state = 1; m_cnt = 0;
      end else if (sc && pc && !pd && sd) begin
        if (m_state == 2) m_pend = 0;
        else if (m_pend) begin
          exp_data = m_word; exp_stb = 1; m_pend = 0;
        end
        m_state = 0;
      end else if (sc && !pc && m_state != 0) begin
        if (m_cnt == 8) begin
          m_cnt = 0;
          if (m_state == 1) begin
            if (m_sh == 8'h36) begin m_state = 2; m_bytes.delete(); end
            else m_state = 0;
          end else if (m_state == 2) begin
            m_bytes.push_back(m_sh);
            if (m_bytes.size() == 3) begin
              m_word = {m_bytes[0], m_bytes[1], m_bytes[2]};
              m_pend = 1; m_state = 3;
            end
          end
        end else begin
          m_sh = {m_sh[6:0], sd};
          m_cnt++;
        end
      end
      s1 <= {scl_m, sda_bus};
      s2 <= s1;
      s3 <= s2;
    end
  end

  // R5: word and strobe compared with the model every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (data_out !== exp_data || update_strobe !== exp_stb) begin
        errors++;
        $display("FAIL R5 cycle compare: data_out=%h strobe=%b expected %h/%b",
                 data_out, update_strobe, exp_data, exp_stb);
      end
    end
  end

  // ---------------- bus master tasks ----------------
  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(5);
    scl_m = 1'b1; wait_clk(5);
    sda_m = 1'b0; wait_clk(5);
    scl_m = 1'b0; wait_clk(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(5);
    scl_m = 1'b1; wait_clk(5);
    sda_m = 1'b1; wait_clk(20);
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(5);
      scl_m = 1'b1; wait_clk(10);
      scl_m = 1'b0; wait_clk(5);
    end
    sda_m = 1'b1; wait_clk(5);
    scl_m = 1'b1; wait_clk(1);
    checks++;
    if (sda_bus !== !exp_ack) begin
      errors++;
      $display("FAIL %s ack for byte %h: sda=%b expected %b", tag, b, sda_bus, !exp_ack);
    end
    wait_clk(8);
    checks++;
    if (sda_bus !== !exp_ack) begin
      errors++;
      $display("FAIL %s ack held for byte %h: sda=%b expected %b", tag, b, sda_bus, !exp_ack);
    end
    wait_clk(1);
    scl_m = 1'b0; wait_clk(5);
    checks++;
    if (sda_oe !== 1'b0) begin
      errors++;
      $display("FAIL R10 sda_oe after ack clock: %b expected 0", sda_oe);
    end
  endtask

  task automatic chk_word(logic [23:0] exp, string tag);
    checks++;
    if (data_out !== exp) begin
      errors++;
      $display("FAIL %s data_out=%h expected %h", tag, data_out, exp);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    checks++;
    if (data_out !== 24'h0 || update_strobe !== 1'b0 || sda_oe !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: data=%h stb=%b oe=%b expected 0/0/0",
               data_out, update_strobe, sda_oe);
    end

    // R2 R4 R5: plain full write
    bus_start();
    send_byte(8'h36, 1, "R2");
    send_byte(8'hA1, 1, "R4");
    send_byte(8'hB2, 1, "R4");
    send_byte(8'hC3, 1, "R4");
    bus_stop();
    chk_word(24'hA1B2C3, "R5");

    // R3: read direction refused, following bytes ignored
    bus_start();
    send_byte(8'h37, 0, "R3");
    send_byte(8'h36, 0, "R3");
    send_byte(8'h55, 0, "R3");
    bus_stop();
    chk_word(24'hA1B2C3, "R3");

    // R3: foreign address
    bus_start();
    send_byte(8'hA0, 0, "R3");
    send_byte(8'h12, 0, "R3");
    bus_stop();
    chk_word(24'hA1B2C3, "R3");

    // R6: pending through repeated STARTs to other targets
    bus_start();
    send_byte(8'h36, 1, "R6");
    send_byte(8'h11, 1, "R6");
    send_byte(8'h22, 1, "R6");
    send_byte(8'h33, 1, "R6");
    bus_start();
    send_byte(8'h50, 0, "R6");
    send_byte(8'h77, 0, "R6");
    chk_word(24'hA1B2C3, "R6");
    bus_start();
    send_byte(8'h9C, 0, "R6");
    chk_word(24'hA1B2C3, "R6");
    bus_stop();
    chk_word(24'h112233, "R6");

    // R7: premature STOP refused, and nothing pending afterwards
    bus_start();
    send_byte(8'h36, 1, "R7");
    send_byte(8'h44, 1, "R7");
    send_byte(8'h55, 1, "R7");
    bus_stop();
    chk_word(24'h112233, "R7");
    bus_start();
    send_byte(8'hA0, 0, "R7");
    bus_stop();
    chk_word(24'h112233, "R7");

    // R8: pending word replaced by a re-addressed full set
    bus_start();
    send_byte(8'h36, 1, "R8");
    send_byte(8'h66, 1, "R8");
    send_byte(8'h77, 1, "R8");
    send_byte(8'h88, 1, "R8");
    bus_start();
    send_byte(8'h36, 1, "R8");
    send_byte(8'h99, 1, "R8");
    send_byte(8'hAA, 1, "R8");
    send_byte(8'hBB, 1, "R8");
    bus_stop();
    chk_word(24'h99AABB, "R8");

    // R8/R7: re-addressed set cut short by STOP: refused, old pending dropped
    bus_start();
    send_byte(8'h36, 1, "R8");
    send_byte(8'h01, 1, "R8");
    send_byte(8'h02, 1, "R8");
    send_byte(8'h03, 1, "R8");
    bus_start();
    send_byte(8'h36, 1, "R8");
    send_byte(8'hDE, 1, "R8");
    bus_stop();
    chk_word(24'h99AABB, "R8");

    // R9: fourth byte not acknowledged and has no effect
    bus_start();
    send_byte(8'h36, 1, "R9");
    send_byte(8'h0A, 1, "R9");
    send_byte(8'h0B, 1, "R9");
    send_byte(8'h0C, 1, "R9");
    send_byte(8'hFF, 0, "R9");
    bus_stop();
    chk_word(24'h0A0B0C, "R9");

    // R11: repeated START mid-set keeps the earlier pending word
    bus_start();
    send_byte(8'h36, 1, "R11");
    send_byte(8'hCC, 1, "R11");
    send_byte(8'hDD, 1, "R11");
    send_byte(8'hEE, 1, "R11");
    bus_start();
    send_byte(8'h36, 1, "R11");
    send_byte(8'h12, 1, "R11");
    bus_start();
    send_byte(8'hA0, 0, "R11");
    bus_stop();
    chk_word(24'hCCDDEE, "R11");

    wait_clk(10);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule